// File: doc/BRIEF.md
# Path-Indexed Loop Visit Predictor

This block forecasts an entire upcoming loop visit from the global branch path that leads to it. It watches the stream of resolved conditional branches. Each one shifts its direction into a path history, and the block keeps the program counter of the most recent branch. On a lookup strobe it hashes that history together with the last branch's program counter into a set of a four-way table. It then confirms the entry with a tag taken from the last branch's program counter.

A hit returns the stored visit: the predicted number of iterations, the loop start address that fetch uses to index a loop cache, and a small direction pattern of in-loop branches for each of up to sixteen iterations. A fetch steering flag is raised only when the prediction hits and promises more than one iteration. Otherwise fetch stays on its normal path.

Training is a separate write port. It carries the observed visit together with the path snapshot and last-branch program counter that preceded the visit. An existing entry with the same tag is refreshed in place. A new key takes an invalid way, or else the least recently used way.

Top module: `loop_visit_pred`

## Requirements
- R1: Every cycle with `br_valid` high shifts `br_taken` into bit 0 of a 16-bit path history (older outcomes move toward bit 15) and records `br_pc` as the last branch; cycles with `br_valid` low leave both unchanged. A branch presented in the same cycle as a lookup is not part of that lookup's key.
- R2: The key is `hist ^ pc[17:2]`. The set index is the 16-bit key folded by XOR into 7 bits: bit i of the key goes into index bit i mod 7. The tag is `pc[13:2]` of the last branch. Training forms the same key from `tr_hist` and `tr_pc`.
- R3: `pr_valid` is high in exactly the cycle after a cycle with `lk_valid` high. All prediction outputs are registered in that same edge.
- R4: `pr_hit` is high only if the indexed set holds a valid entry whose tag equals the lookup tag. On a miss, `pr_iters`, `pr_paths` and `pr_start` read zero.
- R5: `pr_use_loop` is high exactly when `pr_hit` is high and `pr_iters` is greater than 1.
- R6: A hit returns the trained iteration count, start address and path vector unchanged. The pattern of iteration k occupies bits [3k+2:3k] of `pr_paths`.
- R7: Training with a key whose set already holds the tag overwrites that entry, so a later lookup returns the newest data.
- R8: Training with a new tag fills the lowest-numbered invalid way of the set. With no invalid way, it replaces the least recently used way, where lookup hits and training writes both count as use.
- R9: When a lookup and a training write target the same set in the same cycle, the write takes effect and the lookup reports a miss. A training write to a different set does not disturb the lookup.
- R10: After reset every entry is invalid and `pr_valid`, `pr_hit` and `pr_use_loop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A resolved conditional branch is presented |
| br_pc | input | 32 | Program counter of that branch |
| br_taken | input | 1 | Direction of that branch |
| lk_valid | input | 1 | Lookup strobe using the current path history |
| tr_valid | input | 1 | Training write strobe |
| tr_hist | input | 16 | Path history that preceded the observed visit |
| tr_pc | input | 32 | Last branch program counter before the visit |
| tr_iters | input | 8 | Observed iteration count |
| tr_paths | input | 48 | Observed per-iteration direction patterns |
| tr_start | input | 32 | Loop start address |
| pr_valid | output | 1 | Prediction result is present |
| pr_hit | output | 1 | Table hit |
| pr_use_loop | output | 1 | Steer fetch to the loop cache |
| pr_iters | output | 8 | Predicted iteration count |
| pr_paths | output | 48 | Predicted per-iteration direction patterns |
| pr_start | output | 32 | Predicted loop start address |

## Verification
The checker watches several behaviours on every cycle. It checks that history moves only on a valid branch and that each result appears exactly one cycle after its strobe. It checks that a hit never appears without a result, that the steering flag agrees with the hit and the iteration count, and that a same-set collision between a lookup and a write yields a miss. Some behaviours depend on table contents over many operations, and only the directed scenarios can show them. These are the exact fields returned for a key, tag rejection inside a matching set, in-place overwrite, and the choice between an invalid way and the least recently used way.

// File: rtl/loop_visit_pred.sv
module loop_visit_pred #(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int HIST_W = 16,
  parameter int PC_W   = 32,
  parameter int TAG_W  = 12,
  parameter int CNT_W  = 8,
  parameter int ITERS  = 16,
  parameter int PATH_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     br_valid,
  input  logic [PC_W-1:0]          br_pc,
  input  logic                     br_taken,
  input  logic                     lk_valid,
  input  logic                     tr_valid,
  input  logic [HIST_W-1:0]        tr_hist,
  input  logic [PC_W-1:0]          tr_pc,
  input  logic [CNT_W-1:0]         tr_iters,
  input  logic [ITERS*PATH_W-1:0]  tr_paths,
  input  logic [PC_W-1:0]          tr_start,
  output logic                     pr_valid,
  output logic                     pr_hit,
  output logic                     pr_use_loop,
  output logic [CNT_W-1:0]         pr_iters,
  output logic [ITERS*PATH_W-1:0]  pr_paths,
  output logic [PC_W-1:0]          pr_start
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int AGE_W  = WAY_W;
  localparam int PVEC_W = ITERS * PATH_W;

  function automatic logic [IDX_W-1:0] fold(input logic [HIST_W-1:0] k);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < HIST_W; i++) r[i % IDX_W] = r[i % IDX_W] ^ k[i];
    return r;
  endfunction

  logic [HIST_W-1:0] hist_q;
  logic [PC_W-1:0]   last_pc_q;

  logic [WAYS-1:0]   vld_q   [SETS];
  logic [AGE_W-1:0]  age_q   [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q   [SETS][WAYS];
  logic [PVEC_W-1:0] pvec_q  [SETS][WAYS];
  logic [PC_W-1:0]   start_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, tr_set;
  logic [TAG_W-1:0] lk_tag, tr_tag;
  assign lk_set = fold(hist_q ^ last_pc_q[HIST_W+1:2]);
  assign lk_tag = last_pc_q[TAG_W+1:2];
  assign tr_set = fold(tr_hist ^ tr_pc[HIST_W+1:2]);
  assign tr_tag = tr_pc[TAG_W+1:2];

  logic             collide;
  logic             lk_found, tr_found, inv_found;
  logic [WAY_W-1:0] lk_way, tr_hit_way, inv_way, old_way, tr_way;
  logic             lk_go;

  assign collide = lk_valid && tr_valid && (lk_set == tr_set);

  always_comb begin
    lk_found = 1'b0;  lk_way = '0;
    tr_found = 1'b0;  tr_hit_way = '0;
    inv_found = 1'b0; inv_way = '0;
    old_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        lk_found = 1'b1; lk_way = WAY_W'(w);
      end
      if (vld_q[tr_set][w] && tag_q[tr_set][w] == tr_tag) begin
        tr_found = 1'b1; tr_hit_way = WAY_W'(w);
      end
      if (!vld_q[tr_set][w]) begin
        inv_found = 1'b1; inv_way = WAY_W'(w);
      end
      if (age_q[tr_set][w] == AGE_W'(WAYS - 1)) old_way = WAY_W'(w);
    end
  end

  assign tr_way = tr_found ? tr_hit_way : (inv_found ? inv_way : old_way);
  assign lk_go  = lk_valid && lk_found && !collide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q    <= '0;
      last_pc_q <= '0;
    end else if (br_valid) begin
      hist_q    <= {hist_q[HIST_W-2:0], br_taken};
      last_pc_q <= br_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else begin
      if (tr_valid) begin
        vld_q[tr_set][tr_way] <= 1'b1;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == tr_way)
            age_q[tr_set][w] <= '0;
          else if (age_q[tr_set][w] < age_q[tr_set][tr_way])
            age_q[tr_set][w] <= age_q[tr_set][w] + 1'b1;
        end
      end
      if (lk_go) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == lk_way)
            age_q[lk_set][w] <= '0;
          else if (age_q[lk_set][w] < age_q[lk_set][lk_way])
            age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tr_valid) begin
      tag_q[tr_set][tr_way]   <= tr_tag;
      cnt_q[tr_set][tr_way]   <= tr_iters;
      pvec_q[tr_set][tr_way]  <= tr_paths;
      start_q[tr_set][tr_way] <= tr_start;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_valid    <= 1'b0;
      pr_hit      <= 1'b0;
      pr_use_loop <= 1'b0;
      pr_iters    <= '0;
      pr_paths    <= '0;
      pr_start    <= '0;
    end else begin
      pr_valid    <= lk_valid;
      pr_hit      <= lk_go;
      pr_use_loop <= lk_go && (cnt_q[lk_set][lk_way] > CNT_W'(1));
      pr_iters    <= lk_go ? cnt_q[lk_set][lk_way]   : '0;
      pr_paths    <= lk_go ? pvec_q[lk_set][lk_way]  : '0;
      pr_start    <= lk_go ? start_q[lk_set][lk_way] : '0;
    end
  end
endmodule

// File: rtl/loop_visit_pred_chk.sv
module loop_visit_pred_chk #(
  parameter int HIST_W = 16,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic              br_taken,
  input logic              lk_valid,
  input logic              tr_valid,
  input logic [IDX_W-1:0]  lk_set,
  input logic [IDX_W-1:0]  tr_set,
  input logic [HIST_W-1:0] hist_q,
  input logic              pr_valid,
  input logic              pr_hit,
  input logic              pr_use_loop,
  input logic [CNT_W-1:0]  pr_iters
);
  assert_hist_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> hist_q[0] == $past(br_taken));
  assert_hist_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(hist_q));
  assert_result_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pr_valid);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pr_valid);
  assert_hit_needs_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pr_hit |-> pr_valid);
  assert_use_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pr_use_loop == (pr_hit && pr_iters > CNT_W'(1)));
  assert_collision_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && tr_valid && lk_set == tr_set) |=> !pr_hit);
endmodule

bind loop_visit_pred loop_visit_pred_chk #(
  .HIST_W(HIST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
  .lk_valid(lk_valid), .tr_valid(tr_valid), .lk_set(lk_set), .tr_set(tr_set),
  .hist_q(hist_q), .pr_valid(pr_valid), .pr_hit(pr_hit),
  .pr_use_loop(pr_use_loop), .pr_iters(pr_iters)
);

// File: tb/sim_loop_visit_pred.sv
module sim_loop_visit_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0, br_taken = 1'b0, lk_valid = 1'b0, tr_valid = 1'b0;
  logic [31:0] br_pc = '0, tr_pc = '0, tr_start = '0;
  logic [15:0] tr_hist = '0;
  logic [7:0]  tr_iters = '0;
  logic [47:0] tr_paths = '0;
  logic        pr_valid, pr_hit, pr_use_loop;
  logic [7:0]  pr_iters;
  logic [47:0] pr_paths;
  logic [31:0] pr_start;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loop_visit_pred u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc), .br_taken(br_taken),
    .lk_valid(lk_valid), .tr_valid(tr_valid), .tr_hist(tr_hist), .tr_pc(tr_pc),
    .tr_iters(tr_iters), .tr_paths(tr_paths), .tr_start(tr_start),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_use_loop(pr_use_loop),
    .pr_iters(pr_iters), .pr_paths(pr_paths), .pr_start(pr_start)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] hist_for(input logic [15:0] key, input logic [31:0] pc);
    return key ^ pc[17:2];
  endfunction

  function automatic logic [47:0] mk_paths(input logic [7:0] seed);
    logic [47:0] p;
    for (int k = 0; k < 16; k++) p[3*k +: 3] = 3'(seed + 8'(k));
    return p;
  endfunction

  task automatic send_path(input logic [15:0] h, input logic [31:0] pc);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      br_valid = 1'b1;
      br_taken = h[i];
      br_pc    = (i == 0) ? pc : 32'h0000_8000 + 32'(i * 4);
    end
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic train(input logic [15:0] key, input logic [31:0] pc, input logic [7:0] it,
                       input logic [47:0] p, input logic [31:0] st);
    @(negedge clk);
    tr_valid = 1'b1; tr_hist = hist_for(key, pc); tr_pc = pc;
    tr_iters = it; tr_paths = p; tr_start = st;
    @(negedge clk);
    tr_valid = 1'b0;
  endtask

  task automatic lookup();
    @(negedge clk);
    lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic probe(input logic [15:0] key, input logic [31:0] pc, input bit exp_hit, input string req);
    send_path(hist_for(key, pc), pc);
    lookup();
    chk(pr_valid == 1'b1, req, 64'(pr_valid), 64'd1);
    chk(pr_hit == exp_hit, req, 64'(pr_hit), 64'(exp_hit));
  endtask

  task automatic t_reset();
    chk(pr_valid == 0 && pr_hit == 0 && pr_use_loop == 0, "R10", {61'd0, pr_valid, pr_hit, pr_use_loop}, 64'd0);
    probe(16'h0003, 32'h0000_4000, 1'b0, "R10");
    chk(pr_iters == 0 && pr_start == 0 && pr_paths == 0, "R4", 64'(pr_start), 64'd0);
  endtask

  task automatic t_basic();
    logic [47:0] p = mk_paths(8'd1);
    train(16'h0003, 32'h0000_4000, 8'd9, p, 32'h0000_0060);
    probe(16'h0003, 32'h0000_4000, 1'b1, "R4");
    chk(pr_iters == 8'd9, "R6", 64'(pr_iters), 64'd9);
    chk(pr_start == 32'h60, "R6", 64'(pr_start), 64'h60);
    chk(pr_paths == p, "R6", 64'(pr_paths), 64'(p));
    chk(pr_paths[5:3] == 3'd2, "R6", 64'(pr_paths[5:3]), 64'd2);
    chk(pr_use_loop == 1'b1, "R5", 64'(pr_use_loop), 64'd1);
    @(negedge clk);
    chk(pr_valid == 1'b0, "R3", 64'(pr_valid), 64'd0);
  endtask

  task automatic t_single_iter();
    train(16'h0005, 32'h0000_4010, 8'd1, mk_paths(8'd4), 32'h0000_0100);
    probe(16'h0005, 32'h0000_4010, 1'b1, "R5");
    chk(pr_use_loop == 1'b0, "R5", 64'(pr_use_loop), 64'd0);
  endtask

  task automatic t_tag_mismatch();
    probe(16'h0003, 32'h0000_4020, 1'b0, "R2");
    chk(pr_iters == 0, "R4", 64'(pr_iters), 64'd0);
  endtask

  task automatic t_history();
    send_path(hist_for(16'h0003, 32'h0000_4000), 32'h0000_4000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      br_taken = ~br_taken; br_pc = 32'hdead_0000;
    end
    lookup();
    chk(pr_hit == 1'b1, "R1", 64'(pr_hit), 64'd1);
    @(negedge clk);
    br_valid = 1'b1; br_taken = 1'b1; br_pc = 32'h0000_4000;
    @(negedge clk);
    br_valid = 1'b0;
    lookup();
    chk(pr_hit == 1'b0, "R1", 64'(pr_hit), 64'd0);
  endtask

  task automatic t_overwrite();
    train(16'h0003, 32'h0000_4000, 8'd12, mk_paths(8'd7), 32'h0000_0200);
    probe(16'h0003, 32'h0000_4000, 1'b1, "R7");
    chk(pr_iters == 8'd12 && pr_start == 32'h200, "R7", 64'(pr_iters), 64'd12);
  endtask

  task automatic t_lru();
    for (int n = 0; n < 4; n++)
      train(16'h0011, 32'h0000_5000 + 32'(n * 4), 8'(n + 2), mk_paths(8'(n)), 32'h1000 + 32'(n));
    for (int n = 0; n < 4; n++)
      probe(16'h0011, 32'h0000_5000 + 32'(n * 4), 1'b1, "R8");
    probe(16'h0011, 32'h0000_5000, 1'b1, "R8");
    train(16'h0011, 32'h0000_5040, 8'd30, mk_paths(8'd5), 32'h2000);
    probe(16'h0011, 32'h0000_5004, 1'b0, "R8");
    probe(16'h0011, 32'h0000_5000, 1'b1, "R8");
    probe(16'h0011, 32'h0000_5040, 1'b1, "R8");
    chk(pr_iters == 8'd30, "R8", 64'(pr_iters), 64'd30);
    probe(16'h0011, 32'h0000_5008, 1'b1, "R8");
    probe(16'h0011, 32'h0000_500c, 1'b1, "R8");
  endtask

  task automatic t_conflict();
    train(16'h0020, 32'h0000_6000, 8'd3, mk_paths(8'd2), 32'h3000);
    send_path(hist_for(16'h0020, 32'h0000_6000), 32'h0000_6000);
    @(negedge clk);
    lk_valid = 1'b1; tr_valid = 1'b1;
    tr_hist = hist_for(16'h0020, 32'h0000_6004); tr_pc = 32'h0000_6004;
    tr_iters = 8'd6; tr_paths = mk_paths(8'd3); tr_start = 32'h3100;
    @(negedge clk);
    lk_valid = 1'b0; tr_valid = 1'b0;
    chk(pr_valid == 1'b1 && pr_hit == 1'b0, "R9", 64'(pr_hit), 64'd0);
    lookup();
    chk(pr_hit == 1'b1 && pr_iters == 8'd3, "R9", 64'(pr_iters), 64'd3);
    probe(16'h0020, 32'h0000_6004, 1'b1, "R9");
    chk(pr_iters == 8'd6, "R9", 64'(pr_iters), 64'd6);
    send_path(hist_for(16'h0020, 32'h0000_6000), 32'h0000_6000);
    @(negedge clk);
    lk_valid = 1'b1; tr_valid = 1'b1;
    tr_hist = hist_for(16'h0040, 32'h0000_7000); tr_pc = 32'h0000_7000;
    tr_iters = 8'd4; tr_paths = '0; tr_start = 32'h4000;
    @(negedge clk);
    lk_valid = 1'b0; tr_valid = 1'b0;
    chk(pr_hit == 1'b1 && pr_iters == 8'd3, "R9", 64'(pr_iters), 64'd3);
    probe(16'h0040, 32'h0000_7000, 1'b1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single_iter();
    t_tag_mismatch();
    t_history();
    t_overwrite();
    t_lru();
    t_conflict();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule